// File: doc/BRIEF.md
# Pulse Accumulator Counter Unit

This unit is the pulse accumulator of a microcontroller timer. An up-only counter is driven from one external input pin. The unit counts in one of two modes. In event mode it adds one for each chosen edge on the pin. In gated mode it adds one on each tick of a free-running divide-by-64 prescaler, but only while the pin sits at its active level. A single polarity bit picks the counted edge in event mode and the active level in gated mode. The pin is always read as an input, whatever the port direction logic elsewhere does with it.

The pin goes through a two-flop synchronizer and an edge detector in the system clock domain. Software reaches the unit through a small register port with four addresses: control, counter, flags and interrupt enables. There are two sticky flags, one for counter wrap and one for input edges. Writing a 1 to a flag bit clears it. Each flag has its own interrupt enable, and the interrupt output is the OR of the enabled flags.

Top module: `pulse_accum`

## Requirements
- R1: After reset the control, counter, flag and interrupt-enable registers all read 0 and `irq_o` is low.
- R2: In event mode (control bit1 = 0) with enable set (control bit0 = 1), the counter adds one for each selected pin edge: falling when polarity (control bit2) is 0, rising when it is 1. The new value is visible after the third rising clock edge following the pin change.
- R3: In gated mode (control bit1 = 1) with enable set, the counter adds one per prescaler tick while the synchronized pin is active: high for polarity 0, low for polarity 1. Ticks come every 64 clocks, so an active window of exactly 64·K clocks adds exactly K. An inactive pin adds nothing.
- R4: With enable clear, pin activity changes neither the counter nor the flags.
- R5: When an increment takes the counter from 0xFF to 0x00, flag bit0 (overflow) is set. It stays set until cleared, in either mode.
- R6: While enabled, the selected edge sets flag bit1 (input edge) in both modes. In gated mode this is the edge that ends the active level.
- R7: Writing to the flag address clears each flag whose data bit is 1. Bits written as 0 leave their flag unchanged.
- R8: `irq_o` is high exactly when some flag is set and its enable bit (same position, at address 3) is 1.
- R9: The counter (address 1) can be written and read at any time. A write in the same cycle as an increment stores the written value and does not set overflow.
- R10: Address map: 0 = control (bits 7..3 read as 0), 1 = counter, 2 = flags, 3 = interrupt enables (bits 1..0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External accumulator input pin |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong synchronizer depth or edge-select bug shows up at the ports as a miscount, or as a counter change one clock early or late. It is visible on the first edge after enable. A prescaler off by one makes a 64·K window give K±1, and this shows after a few hundred clocks. A broken write-versus-increment priority leaves 0x00 with a raised overflow flag, where the written value should be, and this shows in the very cycle of the collision. Because flags are sticky, a wrongly set flag stays visible on `irq_o` until software clears it.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    typedef struct packed {
        logic pol;
        logic mode;
        logic en;
    } pacc_ctrl_t;

    localparam int CTRL_W = 3;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_CNT  = 2'd1;
    localparam logic [1:0] ADR_FLAG = 2'd2;
    localparam logic [1:0] ADR_IE   = 2'd3;

    localparam int FLG_OVF  = 0;
    localparam int FLG_EDGE = 1;
    localparam int FLG_N    = 2;

endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // shift chain: STAGES synchronizer flops plus one history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o  = ~sh_q[STAGES-1] &  sh_q[STAGES];

    // R2
    edge_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == LAST);

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/pacc_core.sv
module pacc_core #(
    parameter int CW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  pacc_pkg::pacc_ctrl_t    ctrl_i,
    input  logic                    level_i,
    input  logic                    rise_i,
    input  logic                    fall_i,
    input  logic                    tick_i,
    input  logic                    cnt_wr_i,
    input  logic [CW-1:0]           cnt_wdata_i,
    input  logic [pacc_pkg::FLG_N-1:0] flag_clr_i,
    output logic [CW-1:0]           count_o,
    output logic [pacc_pkg::FLG_N-1:0] flags_o
);
    import pacc_pkg::*;

    typedef struct packed {
        logic [CW-1:0]    count;
        logic [FLG_N-1:0] flags;
    } core_st_t;

    core_st_t st_d, st_q;
    logic sel_edge, active, inc, wrap;

    always_comb begin
        sel_edge = ctrl_i.pol ? rise_i : fall_i;
        active   = ctrl_i.pol ? ~level_i : level_i;
        inc      = ctrl_i.en & (ctrl_i.mode ? (tick_i & active) : sel_edge);
        wrap     = inc & ~cnt_wr_i & (st_q.count == '1);

        st_d = st_q;
        if (cnt_wr_i)  st_d.count = cnt_wdata_i;
        else if (inc)  st_d.count = st_q.count + 1'b1;

        st_d.flags = st_q.flags & ~flag_clr_i;
        if (wrap)                    st_d.flags[FLG_OVF]  = 1'b1;
        if (ctrl_i.en && sel_edge)   st_d.flags[FLG_EDGE] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign flags_o = st_q.flags;

    // R9
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (st_q.count == $past(cnt_wdata_i)));

    // R5
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr_i && st_q.count == '1) |=> st_q.flags[FLG_OVF]);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.en && !cnt_wr_i) |=> $stable(st_q.count));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr_i && inc) |=> (st_q.count == CW'($past(st_q.count) + 1'b1)));

endmodule

// File: rtl/pulse_accum.sv
module pulse_accum #(
    parameter int CW       = 8,
    parameter int DIV      = 64,
    parameter int SYNC_STG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_i,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [CW-1:0] bus_wdata,
    output logic [CW-1:0] bus_rdata,
    output logic          irq_o
);
    import pacc_pkg::*;

    typedef struct packed {
        pacc_ctrl_t       ctrl;
        logic [FLG_N-1:0] ie;
    } reg_st_t;

    reg_st_t rg_d, rg_q;

    logic             level, rise, fall, tick;
    logic             cnt_wr;
    logic [FLG_N-1:0] flag_clr;
    logic [CW-1:0]    count;
    logic [FLG_N-1:0] flags;

    pacc_sync_edge #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );

    pacc_prescale #(.DIV(DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    pacc_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .ctrl_i(rg_q.ctrl),
        .level_i(level), .rise_i(rise), .fall_i(fall), .tick_i(tick),
        .cnt_wr_i(cnt_wr), .cnt_wdata_i(bus_wdata), .flag_clr_i(flag_clr),
        .count_o(count), .flags_o(flags)
    );

    always_comb begin
        rg_d     = rg_q;
        cnt_wr   = bus_wr && (bus_addr == ADR_CNT);
        flag_clr = (bus_wr && bus_addr == ADR_FLAG) ? bus_wdata[FLG_N-1:0] : '0;
        if (bus_wr && bus_addr == ADR_CTRL) rg_d.ctrl = bus_wdata[CTRL_W-1:0];
        if (bus_wr && bus_addr == ADR_IE)   rg_d.ie   = bus_wdata[FLG_N-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        unique case (bus_addr)
            ADR_CTRL: bus_rdata = {{(CW-CTRL_W){1'b0}}, rg_q.ctrl};
            ADR_CNT:  bus_rdata = count;
            ADR_FLAG: bus_rdata = {{(CW-FLG_N){1'b0}}, flags};
            default:  bus_rdata = {{(CW-FLG_N){1'b0}}, rg_q.ie};
        endcase
    end

    assign irq_o = |(flags & rg_q.ie);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.ie == '0) |-> !irq_o);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_FLAG && bus_wdata[FLG_OVF] && rg_q.ctrl.en == 1'b0)
        |=> !flags[FLG_OVF]);

endmodule

// File: tb/test_pulse_accum.sv
module test_pulse_accum;
    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    event       rd_ev;

    always #(PERIOD/2) clk = ~clk;

    pulse_accum i_pulse_accum (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares against the read port
    initial begin
        forever begin
            @(rd_ev);
            #1;
            check(rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wreg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        -> rd_ev;
        @(negedge clk);
    endtask

    task automatic waitc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_low();   // high -> low -> high
        @(negedge clk); pin = 1'b0; waitc(5);
        pin = 1'b1; waitc(5);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        waitc(3);
        rst_n = 1'b1;
        waitc(4);
        // R1 reset state
        rreg(2'd0, 8'h00, "R1 ctrl");
        rreg(2'd1, 8'h00, "R1 count");
        rreg(2'd2, 8'h00, "R1 flags");
        rreg(2'd3, 8'h00, "R1 ie");
        check({7'd0, irq}, 8'h00, "R1 irq");

        // R4 disabled: edges ignored
        for (int i = 0; i < 3; i++) pulse_low();
        rreg(2'd1, 8'h00, "R4 count");
        rreg(2'd2, 8'h00, "R4 flags");

        // R2 event mode, falling edge
        wreg(2'd0, 8'h01);
        for (int i = 0; i < 5; i++) pulse_low();
        rreg(2'd1, 8'h05, "R2 falling count");
        rreg(2'd2, 8'h02, "R6 edge flag event");

        // R7 write-one-to-clear
        wreg(2'd2, 8'h01);
        rreg(2'd2, 8'h02, "R7 zero bit keeps flag");
        wreg(2'd2, 8'h02);
        rreg(2'd2, 8'h00, "R7 clear");

        // R2 rising edge
        wreg(2'd0, 8'h05);
        for (int i = 0; i < 3; i++) pulse_low();
        rreg(2'd1, 8'h08, "R2 rising count");

        // R9 write/read, R5 overflow
        wreg(2'd1, 8'hFF);
        rreg(2'd1, 8'hFF, "R9 readback");
        pulse_low();
        rreg(2'd1, 8'h00, "R5 wrap count");
        rreg(2'd2, 8'h03, "R5 ovf flag");
        pulse_low();
        rreg(2'd2, 8'h03, "R5 sticky");
        rreg(2'd1, 8'h01, "R2 after wrap");
        check({7'd0, irq}, 8'h00, "R8 masked");
        wreg(2'd3, 8'h01);
        check({7'd0, irq}, 8'h01, "R8 ovf enabled");
        wreg(2'd3, 8'h02);
        check({7'd0, irq}, 8'h01, "R8 edge enabled");
        wreg(2'd2, 8'h03);
        check({7'd0, irq}, 8'h00, "R8 cleared");
        wreg(2'd3, 8'h00);

        // R9 write collides with increment
        wreg(2'd1, 8'hFF);
        @(negedge clk); pin = 1'b0; waitc(5);
        wreg(2'd2, 8'h03);
        @(negedge clk); pin = 1'b1;
        @(negedge clk);
        wreg(2'd1, 8'h10);
        waitc(4);
        rreg(2'd1, 8'h10, "R9 write wins");
        rreg(2'd2, 8'h02, "R9 no overflow");

        // R3 gated, active high
        @(negedge clk); pin = 1'b0; waitc(5);
        wreg(2'd0, 8'h03);
        wreg(2'd1, 8'h00);
        wreg(2'd2, 8'h03);
        @(negedge clk); pin = 1'b1;
        waitc(256);
        pin = 1'b0;
        waitc(5);
        rreg(2'd1, 8'h04, "R3 gated high 4 ticks");
        rreg(2'd2, 8'h02, "R6 gated end edge");

        // R3 gated, active low, with R5 overflow
        @(negedge clk); pin = 1'b1; waitc(5);
        wreg(2'd0, 8'h07);
        wreg(2'd1, 8'hFE);
        wreg(2'd2, 8'h03);
        @(negedge clk); pin = 1'b0;
        waitc(192);
        pin = 1'b1;
        waitc(5);
        rreg(2'd1, 8'h01, "R3 gated low count");
        rreg(2'd2, 8'h03, "R5 gated ovf");
        waitc(200);
        rreg(2'd1, 8'h01, "R3 inactive no count");

        // R10 control reserved bits
        wreg(2'd0, 8'hFF);
        rreg(2'd0, 8'h07, "R10 ctrl bits");
        wreg(2'd3, 8'hFF);
        rreg(2'd3, 8'h03, "R10 ie bits");

        waitc(3);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule